// File: doc/BRIEF.md
# Bank-Switched LCD Segment Memory

This block is a byte-wide data memory in which a small window of addresses can be steered either to ordinary storage or to a segment display memory. An 8-bit bank register lives at address 04H. When that register holds 01H and the processor reaches address 40H through 52H with the indirect-pointer flag set, the access lands in one of 19 display bytes instead of the general RAM at the same address. Every other combination, including any direct access and any bank value other than 01H, reaches the general RAM.

Each display byte belongs to one segment: address 40H+k is segment k. Bit c of that byte lights segment k on common c, for a four-common panel. A 1 turns the segment on and a 0 turns it off. Only the low four bits are stored, and the upper four read back as zero. A refresh port takes a common index and returns the 19 segment bits for that common as a combinational read, so a display write shows up on the refresh port directly after the clock edge that stores it.

Top module: `lcd_bank_ram`

## Requirements
- R1: Address 04H is the 8-bit bank register. It can be written and read with direct or indirect access, and reset sets it to 00H.
- R2: With the bank register at 01H, an indirect access (cpu_ind=1) to 40H..52H reaches display byte (addr-40H). A write stores cpu_wdata[3:0]. A read returns the stored nibble in bits 3:0 and 0 in bits 7:4.
- R3: With the bank register at any value other than 01H, indirect accesses to 40H..52H reach general RAM and leave the display memory unchanged.
- R4: Direct accesses (cpu_ind=0) to 40H..52H always reach general RAM and never change the display memory, whatever the bank register holds.
- R5: Display bytes and general RAM at the same address are separate storage. Writing one does not change what the other reads back.
- R6: scan_seg[k] equals bit scan_com of display byte k, for k 0..18 and scan_com 0..3. It is combinational, so a display write is visible on scan_seg in the cycle after its clock edge.
- R7: Reset clears every display bit to 0, so scan_seg is all zero for every common after reset.
- R8: Addresses outside 40H..52H, other than 04H, always reach general RAM. cpu_rdata is a combinational read of the addressed location.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 8 | Byte address |
| cpu_ind | input | 1 | 1 when the access goes through the indirect pointer |
| cpu_we | input | 1 | Write strobe, taken at the rising clock edge |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Combinational read data for cpu_addr |
| scan_com | input | 2 | Common index for the refresh read |
| scan_seg | output | 19 | Segment bits of the selected common |

## Verification
Both read paths are combinational, so a read is due in the same cycle as its address. A write changes the state seen on cpu_rdata and scan_seg from the cycle after its rising edge onward. The bench drives each step at the falling edge and compares both outputs with its model shortly after. It then updates the model at the following rising edge, so every comparison uses the state from all earlier edges and none from the current one.

// File: rtl/lcd_bank_ram.sv
module lcd_bank_ram #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int SEGS = 19,
  parameter int COMS = 4,
  parameter logic [7:0] BASE = 8'h40,
  parameter logic [7:0] BANK_ADDR = 8'h04,
  parameter logic [7:0] DISP_BANK = 8'h01,
  localparam int CW = $clog2(COMS),
  localparam int SW = $clog2(SEGS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   cpu_addr,
  input  logic            cpu_ind,
  input  logic            cpu_we,
  input  logic [DW-1:0]   cpu_wdata,
  output logic [DW-1:0]   cpu_rdata,
  input  logic [CW-1:0]   scan_com,
  output logic [SEGS-1:0] scan_seg
);
  localparam logic [AW-1:0] LO = AW'(BASE);
  localparam logic [AW-1:0] HI = AW'(BASE + SEGS - 1);

  logic [DW-1:0] ram [2**AW];
  logic [DW-1:0] bank_q;
  logic [SEGS*COMS-1:0] disp_q;

  logic [AW-1:0] off;
  logic [SW-1:0] idx;
  logic in_win, disp_sel, bank_sel;
  logic [COMS-1:0] nib;

  assign off      = cpu_addr - LO;
  assign idx      = off[SW-1:0];
  assign in_win   = (cpu_addr >= LO) && (cpu_addr <= HI);
  assign bank_sel = cpu_addr == AW'(BANK_ADDR);
  assign disp_sel = cpu_ind && (bank_q == DW'(DISP_BANK)) && in_win;
  assign nib      = disp_q[idx*COMS +: COMS];

  assign cpu_rdata = bank_sel ? bank_q :
                     disp_sel ? {{(DW-COMS){1'b0}}, nib} :
                     ram[cpu_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bank_q <= '0;
      disp_q <= '0;
    end else if (cpu_we) begin
      if (bank_sel) bank_q <= cpu_wdata;
      else if (disp_sel) disp_q[idx*COMS +: COMS] <= cpu_wdata[COMS-1:0];
    end
  end

  always_ff @(posedge clk)
    if (cpu_we && !bank_sel && !disp_sel) ram[cpu_addr] <= cpu_wdata;

  for (genvar k = 0; k < SEGS; k++) begin : g_scan
    assign scan_seg[k] = disp_q[k*COMS + int'(scan_com)];
  end
endmodule

module lcd_bank_ram_chk #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter int SEGS = 19,
  parameter int COMS = 4,
  parameter logic [7:0] BASE = 8'h40,
  parameter logic [7:0] BANK_ADDR = 8'h04,
  parameter logic [7:0] DISP_BANK = 8'h01
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [AW-1:0]        cpu_addr,
  input logic                 cpu_ind,
  input logic                 cpu_we,
  input logic [DW-1:0]        cpu_wdata,
  input logic [DW-1:0]        cpu_rdata,
  input logic [DW-1:0]        bank_q,
  input logic [SEGS*COMS-1:0] disp_q
);
  logic win;
  assign win = (cpu_addr >= AW'(BASE)) && (cpu_addr <= AW'(BASE + SEGS - 1));

  a_r1_bank_write: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_we && cpu_addr == AW'(BANK_ADDR) |=> bank_q == $past(cpu_wdata));

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ind && bank_q == DW'(DISP_BANK) && win |-> cpu_rdata[DW-1:COMS] == '0);

  a_r3_other_bank_keeps_disp: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_we && bank_q != DW'(DISP_BANK) |=> $stable(disp_q));

  a_r4_direct_keeps_disp: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_we && !cpu_ind |=> $stable(disp_q));

  a_r6_first_byte_stored: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_we && cpu_ind && bank_q == DW'(DISP_BANK) && cpu_addr == AW'(BASE)
    |=> disp_q[COMS-1:0] == $past(cpu_wdata[COMS-1:0]));
endmodule

bind lcd_bank_ram lcd_bank_ram_chk #(
  .AW(AW), .DW(DW), .SEGS(SEGS), .COMS(COMS),
  .BASE(BASE), .BANK_ADDR(BANK_ADDR), .DISP_BANK(DISP_BANK)
) u_chk (.*);

// File: tb/tb_lcd_bank_ram.sv
`timescale 1ns/1ps
module tb_lcd_bank_ram;
  logic clk = 0, rst_n = 0;
  logic [7:0] cpu_addr = 0, cpu_wdata = 0;
  logic cpu_ind = 0, cpu_we = 0;
  logic [1:0] scan_com = 0;
  logic [7:0] cpu_rdata;
  logic [18:0] scan_seg;

  lcd_bank_ram dut (.*);

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  byte unsigned m_ram [256];
  bit m_valid [256];
  byte unsigned m_bank;
  bit [3:0] m_disp [19];

  function automatic bit is_disp(input int a, input bit ind);
    return ind && m_bank == 8'h01 && a >= 'h40 && a <= 'h52;
  endfunction

  function automatic string tag_of(input int a, input bit ind);
    if (a == 4) return "R1";
    if (is_disp(a, ind)) return "R2";
    if (a >= 'h40 && a <= 'h52) return ind ? "R3" : "R4";
    return "R8";
  endfunction

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [18:0] seg_exp(input int c);
    logic [18:0] v;
    for (int k = 0; k < 19; k++) v[k] = m_disp[k][c];
    return v;
  endfunction

  task automatic step(input int a, input int wd, input bit we, input bit ind, input int c, input string rtag = "");
    string t;
    @(negedge clk);
    cpu_addr = 8'(a); cpu_wdata = 8'(wd); cpu_we = we; cpu_ind = ind; scan_com = 2'(c);
    #1;
    t = (rtag != "") ? rtag : tag_of(a, ind);
    if (a == 4) chk(t, cpu_rdata, m_bank);
    else if (is_disp(a, ind)) chk(t, cpu_rdata, {4'h0, m_disp[a - 'h40]});
    else if (m_valid[a]) chk(t, cpu_rdata, m_ram[a]);
    chk("R6", scan_seg, seg_exp(c));
    @(posedge clk);
    if (we) begin
      if (a == 4) m_bank = 8'(wd);
      else if (is_disp(a, ind)) m_disp[a - 'h40] = 4'(wd);
      else begin m_ram[a] = 8'(wd); m_valid[a] = 1; end
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; cpu_we = 0;
    @(posedge clk); m_bank = 0;
    for (int k = 0; k < 19; k++) m_disp[k] = 0;
    @(negedge clk); rst_n = 1;
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    do_reset();
    // R1 and R7: state right after reset
    for (int c = 0; c < 4; c++) step(4, 0, 0, 0, c, "R1");
    for (int c = 0; c < 4; c++) step('h40 + c, 0, 0, 0, c, "R7");
    // R5: separate storage at the same address
    step('h45, 'hAA, 1, 0, 0);
    step(4, 1, 1, 0, 0);
    step('h45, 'hFF, 1, 1, 1);
    step('h45, 0, 0, 0, 1, "R5");
    step('h45, 0, 0, 1, 3, "R5");
    step('h45, 'h3C, 1, 0, 2);
    step('h45, 0, 0, 1, 2, "R5");
    // R2/R6: end bytes of the window and bit-to-common mapping
    step('h40, 'hF1, 1, 1, 0);
    step('h52, 'h18, 1, 1, 3);
    for (int c = 0; c < 4; c++) step('h52, 0, 0, 1, c, "R2");
    for (int c = 0; c < 4; c++) step('h40, 0, 0, 1, c, "R6");
    // R3: other bank values
    step(4, 'h02, 1, 1, 0);
    step('h41, 'h0F, 1, 1, 0);
    step('h41, 0, 0, 1, 0, "R3");
    step(4, 'hFF, 1, 0, 1);
    step('h50, 'h77, 1, 1, 1);
    step('h50, 0, 0, 1, 1, "R3");
    // R8: edges of the window belong to RAM
    step('h3F, 'h5A, 1, 1, 2);
    step('h53, 'hA5, 1, 1, 2);
    step(4, 1, 1, 1, 0);
    step('h3F, 0, 0, 1, 0, "R8");
    step('h53, 0, 0, 1, 0, "R8");
    // random traffic against the model
    for (int i = 0; i < 3000; i++) begin
      int a, sel, wd;
      sel = $urandom_range(0, 9);
      if (sel == 0) begin
        a = 4;
        wd = $urandom_range(0, 3);
        wd = (wd == 3) ? 'hFF : wd;
        if ($urandom_range(0, 1) == 1) wd = 1;
      end else if (sel < 7) begin
        a = $urandom_range('h3F, 'h53); wd = $urandom_range(0, 255);
      end else begin
        a = $urandom_range(0, 255); wd = $urandom_range(0, 255);
      end
      step(a, wd, $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 3));
      if (i == 1500) begin
        do_reset();
        for (int c = 0; c < 4; c++) step(4, 0, 0, 0, c, "R7");
      end
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule